// File: doc/BRIEF.md
# Eight-Sample Average and Midrange Unit

This block takes in a burst of unsigned bytes framed by a synchronous reset pulse and reports two statistics about it. The mean of the burst appears on one output. The midpoint between the largest and smallest byte appears on the other. While the burst arrives, the block keeps a running sum, a running maximum and a running minimum.

A caller holds the reset high for one or more clocks and then drops it. The block samples the data input on each of the next eight rising edges. On the ninth edge it loads both results into output registers and raises a valid strobe for one cycle. The results then stay on the outputs until the next reset pulse. Data presented after the burst has no effect. A reset in the middle of a burst discards everything captured so far.

The burst length is a power of two, set by a parameter (default 8). The sample width is also a parameter (default 8).

Top module: `burst_avg_midrange`

## Requirements
- R1: A rising clock edge with `rst_i` high clears `mean_o`, `mid_o` and `valid_o` to 0 in the following cycle.
- R2: Let edge 1 be the first rising edge with `rst_i` low after one or more edges with `rst_i` high. The block samples `din_i` on edges 1 through 8 and on no other edge.
- R3: After edge 9, `mean_o` equals the sum of the eight sampled bytes divided by 8, with the remainder dropped.
- R4: After edge 9, `mid_o` equals (largest sampled byte + smallest sampled byte) / 2, with the remainder dropped. Bytes are compared as unsigned values.
- R5: `valid_o` is 1 for exactly the one cycle that follows edge 9, and 0 at all other times.
- R6: After edge 9 and until the next edge with `rst_i` high, `mean_o` and `mid_o` hold their values whatever `din_i` does.
- R7: If `rst_i` is high on any edge during a burst, the bytes captured so far are discarded. Capture restarts from the next edge with `rst_i` low, and that edge counts as edge 1.
- R8: The running sum cannot overflow. Eight bytes of 255 give `mean_o` = 255 and `mid_o` = 255.
- R9: The first sampled byte initialises both the running maximum and the running minimum. If the first byte is the largest or the smallest of the burst, the midpoint still uses it.
- R10: During edges 1 to 8, `mean_o` and `mid_o` stay 0 and `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every register updates on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high; dropping it starts a burst |
| din_i | input | 8 | Unsigned sample byte |
| mean_o | output | 8 | Mean of the burst, rounded down |
| mid_o | output | 8 | Midpoint of the burst's maximum and minimum, rounded down |
| valid_o | output | 1 | One-cycle strobe when the results are first shown |

## Verification
The bench runs several bursts:
- An ascending ramp checks the sum and the extreme tracking together.
- An all-255 burst checks that the sum has enough headroom.
- A burst that opens with its maximum, and another that opens with its minimum, show whether the first byte seeds both extremes.
- A constant burst gives identical mean and midpoint.
- A burst with a mid-sequence reset, and a long reset hold, show whether stale samples leak into the next result or the edge count slips.

Toggling the data after completion separates a design that holds its results from one that keeps capturing.

// File: rtl/burst_stat_pkg.sv
package burst_stat_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_CAPTURE = 2'd1,
      ST_DONE    = 2'd2
   } seq_state_t;

   // Comparator direction for an extreme tracker
   typedef enum logic {
      EXT_MIN = 1'b0,
      EXT_MAX = 1'b1
   } ext_kind_t;

endpackage

// File: rtl/stat_seq_ctrl.sv
module stat_seq_ctrl
   import burst_stat_pkg::*;
#(
   parameter int SAMPLES_LOG2 = 3
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   output logic                  take_o,
   output logic                  first_o,
   output logic                  finish_o,
   output seq_state_t            state_o,
   output logic [SAMPLES_LOG2:0] cnt_o
);
   localparam int CNT_W   = SAMPLES_LOG2 + 1;
   localparam int SAMPLES = 1 << SAMPLES_LOG2;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLES);

   seq_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      take_o   = 1'b0;
      first_o  = 1'b0;
      finish_o = 1'b0;
      if (rst_i) begin
         state_d = ST_IDLE;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               take_o  = 1'b1;
               first_o = 1'b1;
               cnt_d   = CNT_W'(1);
               state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
               if (cnt_q == CNT_FULL) begin
                  finish_o = 1'b1;
                  state_d  = ST_DONE;
               end else begin
                  take_o = 1'b1;
                  cnt_d  = cnt_q + CNT_W'(1);
               end
            end
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_DONE;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
   end

   assign state_o = state_q;
   assign cnt_o   = cnt_q;

   AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= CNT_FULL);                                             // R2
   AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_DONE) |=> (state_q == ST_DONE));                 // R6
   AST_RST_IDLE: assert property (@(posedge clk_i)
      rst_i |=> (state_q == ST_IDLE && cnt_q == '0));                 // R7

endmodule

// File: rtl/stat_accum.sv
module stat_accum #(
   parameter int DATA_W       = 8,
   parameter int SAMPLES_LOG2 = 3
) (
   input  logic                           clk_i,
   input  logic                           clr_i,
   input  logic                           add_i,
   input  logic [DATA_W-1:0]              din_i,
   output logic [DATA_W+SAMPLES_LOG2-1:0] sum_o
);
   localparam int SUM_W = DATA_W + SAMPLES_LOG2;

   logic [SUM_W-1:0] sum_q;

   always_ff @(posedge clk_i) begin
      if (clr_i)      sum_q <= '0;
      else if (add_i) sum_q <= sum_q + SUM_W'(din_i);
   end

   assign sum_o = sum_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (clr_i)
      add_i |=> (sum_q >= $past(sum_q)));                             // R8

endmodule

// File: rtl/stat_extreme.sv
module stat_extreme
   import burst_stat_pkg::*;
#(
   parameter int        DATA_W = 8,
   parameter ext_kind_t KIND   = EXT_MAX
) (
   input  logic              clk_i,
   input  logic              clr_i,
   input  logic              first_i,
   input  logic              upd_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] val_o
);
   logic [DATA_W-1:0] val_q;
   logic              wins;

   generate
      if (KIND == EXT_MAX) begin : g_max
         assign wins = din_i > val_q;
      end else begin : g_min
         assign wins = din_i < val_q;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (clr_i)             val_q <= '0;
      else if (first_i)      val_q <= din_i;
      else if (upd_i && wins) val_q <= din_i;
   end

   assign val_o = val_q;

   AST_FIRST_SEED: assert property (@(posedge clk_i) disable iff (clr_i)
      first_i |=> (val_q == $past(din_i)));                           // R9

endmodule

// File: rtl/stat_result.sv
module stat_result #(
   parameter int DATA_W       = 8,
   parameter int SAMPLES_LOG2 = 3
) (
   input  logic                           clk_i,
   input  logic                           clr_i,
   input  logic                           load_i,
   input  logic [DATA_W+SAMPLES_LOG2-1:0] sum_i,
   input  logic [DATA_W-1:0]              max_i,
   input  logic [DATA_W-1:0]              min_i,
   output logic [DATA_W-1:0]              mean_o,
   output logic [DATA_W-1:0]              mid_o,
   output logic                           valid_o
);
   localparam int SUM_W = DATA_W + SAMPLES_LOG2;
   localparam int TOT_W = DATA_W + 1;

   logic [TOT_W-1:0]  span_tot;
   logic [DATA_W-1:0] mean_q, mid_q;
   logic              valid_q;

   assign span_tot = TOT_W'(max_i) + TOT_W'(min_i);

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         mean_q  <= '0;
         mid_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= load_i;
         if (load_i) begin
            mean_q <= sum_i[SUM_W-1:SAMPLES_LOG2];
            mid_q  <= span_tot[TOT_W-1:1];
         end
      end
   end

   assign mean_o  = mean_q;
   assign mid_o   = mid_q;
   assign valid_o = valid_q;

   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (clr_i)
      valid_q |=> !valid_q);                                          // R5
   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (clr_i)
      !load_i |=> ($stable(mean_q) && $stable(mid_q)));               // R6

endmodule

// File: rtl/burst_avg_midrange.sv
module burst_avg_midrange
   import burst_stat_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SAMPLES_LOG2 = 3
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] mean_o,
   output logic [DATA_W-1:0] mid_o,
   output logic              valid_o
);
   localparam int SUM_W = DATA_W + SAMPLES_LOG2;
   localparam int CNT_W = SAMPLES_LOG2 + 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("burst_avg_midrange: DATA_W must be at least 2");
      end
      if (SAMPLES_LOG2 < 1 || SAMPLES_LOG2 > 8) begin : g_bad_len
         $error("burst_avg_midrange: SAMPLES_LOG2 must be 1..8");
      end
   endgenerate

   logic              take, first, finish;
   seq_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [SUM_W-1:0]  sum;
   logic [DATA_W-1:0] ext_val [2];

   stat_seq_ctrl #(.SAMPLES_LOG2(SAMPLES_LOG2)) u_ctrl (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .take_o   (take),
      .first_o  (first),
      .finish_o (finish),
      .state_o  (state),
      .cnt_o    (cnt)
   );

   stat_accum #(.DATA_W(DATA_W), .SAMPLES_LOG2(SAMPLES_LOG2)) u_accum (
      .clk_i (clk_i),
      .clr_i (rst_i),
      .add_i (take),
      .din_i (din_i),
      .sum_o (sum)
   );

   // index 0 tracks the minimum, index 1 the maximum
   generate
      for (genvar g = 0; g < 2; g++) begin : g_ext
         stat_extreme #(
            .DATA_W (DATA_W),
            .KIND   ((g == 1) ? EXT_MAX : EXT_MIN)
         ) u_ext (
            .clk_i   (clk_i),
            .clr_i   (rst_i),
            .first_i (first),
            .upd_i   (take),
            .din_i   (din_i),
            .val_o   (ext_val[g])
         );
      end
   endgenerate

   stat_result #(.DATA_W(DATA_W), .SAMPLES_LOG2(SAMPLES_LOG2)) u_result (
      .clk_i   (clk_i),
      .clr_i   (rst_i),
      .load_i  (finish),
      .sum_i   (sum),
      .max_i   (ext_val[1]),
      .min_i   (ext_val[0]),
      .mean_o  (mean_o),
      .mid_o   (mid_o),
      .valid_o (valid_o)
   );

   AST_RST_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> (mean_o == '0 && mid_o == '0 && !valid_o));           // R1
   AST_MIN_LE_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
      (state != ST_IDLE && cnt != '0) |-> (ext_val[0] <= ext_val[1])); // R4
   AST_QUIET_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
      (state == ST_CAPTURE) |-> (!valid_o && mean_o == '0));          // R10

endmodule

// File: tb/burst_avg_midrange_tb.sv
`timescale 1ns/1ps
module burst_avg_midrange_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] din = 8'h00;
   logic [7:0] mean_w, mid_w;
   logic       valid_w;

   int checks = 0;
   int errors = 0;

   // reference model state
   int  ref_q[$];
   bit  ref_armed = 0;
   int  exp_mean  = 0;
   int  exp_mid   = 0;
   int  exp_valid = 0;

   always #2 clk = ~clk;

   burst_avg_midrange dut_i (
      .clk_i   (clk),
      .rst_i   (rst),
      .din_i   (din),
      .mean_o  (mean_w),
      .mid_o   (mid_w),
      .valid_o (valid_w)
   );

   task automatic model_step(input bit r, input int d);
      if (r) begin
         exp_mean = 0; exp_mid = 0; exp_valid = 0;
         ref_armed = 1; ref_q.delete();
      end else begin
         exp_valid = 0;
         if (ref_armed) begin
            if (ref_q.size() < 8) ref_q.push_back(d);
            else begin
               int s = 0, mx = 0, mn = 255;
               foreach (ref_q[i]) begin
                  s += ref_q[i];
                  if (ref_q[i] > mx) mx = ref_q[i];
                  if (ref_q[i] < mn) mn = ref_q[i];
               end
               exp_mean = s / 8; exp_mid = (mx + mn) / 2;
               exp_valid = 1; ref_armed = 0;
            end
         end
      end
   endtask

   task automatic check(input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t",
                  tag, what, act, exp, $time);
      end
   endtask

   // one clock: drive away from edge, update model, compare after edge
   task automatic cyc(input bit r, input int d, input string tag);
      @(negedge clk);
      rst = r; din = 8'(d);
      @(posedge clk);
      #1;
      model_step(r, d);
      check(tag, "mean", int'(mean_w), exp_mean);
      check(tag, "mid", int'(mid_w), exp_mid);
      check(tag, "valid", int'(valid_w), exp_valid);
   endtask

   task automatic burst(input int b[8], input string tag);
      cyc(1, 8'hA5, "R1");
      foreach (b[i]) cyc(0, b[i], "R2_R10");
      cyc(0, 8'h3C, tag);       // edge 9: results appear
      cyc(0, 8'hFF, "R5_R6");   // strobe drops, result holds
      cyc(0, 8'h00, "R6");
   endtask

   initial begin : watchdog
      #40000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int ramp[8]   = '{1, 2, 3, 4, 5, 6, 7, 8};
      int full[8]   = '{255, 255, 255, 255, 255, 255, 255, 255};
      int hifst[8]  = '{200, 10, 50, 60, 70, 80, 90, 11};
      int lofst[8]  = '{3, 100, 120, 250, 90, 91, 92, 93};
      int flat[8]   = '{77, 77, 77, 77, 77, 77, 77, 77};
      int mix[8]    = '{0, 255, 17, 128, 64, 9, 33, 1};
      cyc(1, 0, "R1");
      cyc(1, 0, "R1");
      burst(ramp,  "R3_R4_R5");
      burst(full,  "R8");
      burst(hifst, "R9_R4");
      burst(lofst, "R9_R3");
      burst(flat,  "R3_R4");
      // R6: long idle with toggling data after completion
      for (int k = 0; k < 6; k++) cyc(0, k * 40, "R6");
      // R7: abort mid-burst, then full burst counted from fresh edge 1
      cyc(1, 0, "R1");
      for (int k = 0; k < 5; k++) cyc(0, 250, "R7");
      cyc(1, 0, "R7");
      cyc(1, 0, "R7");
      foreach (mix[i]) cyc(0, mix[i], "R7_R2");
      cyc(0, 200, "R7_R3_R4");
      cyc(0, 200, "R5");
      cyc(0, 200, "R6");
      burst(mix, "R2_R3_R4");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule